// File: doc/BRIEF.md
# Interleaved Memory Ready Sequencer

This block paces processor accesses to a memory made of two interleaved 32-bit DRAM banks plus a byte-wide boot ROM. It samples a request together with the top address bits, address bit 2 and a burst flag. From these it drives two registered strobes. `rdy` tells the processor that a data beat is complete. `inc` advances the external column-address pre-counter from one bank to the other.

For DRAM the strobes are phased against the bank that the transfer starts in. When the first word sits in the odd bank, `inc` fires one cycle ahead of the first `rdy`. A ROM access does not use the DRAM sequence. Instead it runs a fixed three-cycle pattern on the same `rdy` and `inc` registers and drives the ROM chip select.

Cycle numbering: cycle 1 is the first clock cycle after the rising edge that samples the request.

Top module: `ilv_ready_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `busy`, `rdy` and `inc` at the next clock edge, including in the middle of a transfer. `rom_cs_n` is high (deasserted) whenever `rst` is high.
- R2: While idle, a request with `addr_hi` = 2'b01 is a DRAM access. `busy` is high from cycle 1, and `rdy` stays low in cycles 1 and 2.
- R3: A DRAM access with `addr_b2` = 0 raises `rdy` and `inc` together for the first time in cycle 3.
- R4: A DRAM access with `addr_b2` = 1 raises `inc` in cycle 3 and the first `rdy` in cycle 4, so `inc` leads `rdy` by one cycle.
- R5: If `burst` is low when the request is sampled, `rdy` is high for exactly one cycle. `busy` then drops in the following cycle, whatever `burst` does later.
- R6: If `burst` is high when the request is sampled, `rdy` stays high in every cycle after the first one for as long as `burst` was high in the previous `rdy` cycle. The transfer ends, with `busy`, `rdy` and `inc` all low, in the cycle after a `rdy` cycle in which `burst` is low.
- R7: After its first assertion in cycle 3, `inc` alternates high and low every cycle until the transfer ends.
- R8: While idle, a request with `addr_hi` = 2'b00 is a ROM access. `inc` is high in cycles 1 and 2, `rdy` is high in cycle 2 only, and both are low in cycle 3. `rom_cs_n` is low in cycles 1 and 2, and `busy` stays low throughout.
- R9: A request with `addr_hi[1]` = 1 is unmapped. It produces no `rdy`, no `inc`, no `busy` and no ROM select.
- R10: A request that arrives while a DRAM transfer is in progress is ignored. The transfer's strobe pattern is unchanged and `rom_cs_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Processor access request |
| burst | input | 1 | Processor burst flag |
| addr_hi | input | 2 | Address bits 31:30, used for region decode |
| addr_b2 | input | 1 | Address bit 2, selects the starting bank |
| busy | output | 1 | DRAM access in progress |
| rdy | output | 1 | Registered ready to the processor |
| inc | output | 1 | Bank-to-bank column pre-counter increment |
| rom_cs_n | output | 1 | Boot ROM chip select, active low |

## Verification
A wrong cycle count or a lost starting-bank bit appears at the ports within four cycles of the request, as a first `rdy` that arrives early or late, or as an `inc` that does not lead `rdy` by one cycle for odd-bank starts. A corrupted burst latch or end condition shows up at the first `rdy` cycle, as one beat too many or too few, or as `busy` that never falls. A wrong `inc` phase breaks the alternation on the very next cycle. A stuck ROM phase shows within three cycles on `rom_cs_n` and `rdy`.

// File: rtl/ilv_ready_seq.sv
module ilv_ready_seq #(
  parameter int INC_START = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       burst,
  input  logic [1:0] addr_hi,
  input  logic       addr_b2,
  output logic       busy,
  output logic       rdy,
  output logic       inc,
  output logic       rom_cs_n
);

  localparam int CMAX_I = INC_START + 1;
  localparam int CW = $clog2(CMAX_I + 2);
  localparam logic [CW-1:0] K_INC  = CW'(INC_START);
  localparam logic [CW-1:0] K_ODD  = CW'(INC_START + 1);
  localparam logic [CW-1:0] K_ONE  = CW'(1);

  logic [CW-1:0] cnt, nxt, first_rdy;
  logic [1:0]    rom_ph;
  logic          a2q, bq;
  logic          idle, dram_hit, rom_hit, done;

  assign idle      = !busy && (rom_ph == 2'd0);
  assign dram_hit  = (addr_hi == 2'b01);
  assign rom_hit   = (addr_hi == 2'b00);
  assign nxt       = cnt + K_ONE;
  assign first_rdy = a2q ? K_ODD : K_INC;
  assign done      = rdy && !(bq && burst);
  assign rom_cs_n  = rst || (rom_ph == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      rdy    <= 1'b0;
      inc    <= 1'b0;
      cnt    <= '0;
      rom_ph <= 2'd0;
      a2q    <= 1'b0;
      bq     <= 1'b0;
    end else if (idle && req && dram_hit) begin
      busy <= 1'b1;
      cnt  <= K_ONE;
      a2q  <= addr_b2;
      bq   <= burst;
    end else if (idle && req && rom_hit) begin
      rom_ph <= 2'd1;
      inc    <= 1'b1;
    end else if (rom_ph == 2'd1) begin
      rom_ph <= 2'd2;
      rdy    <= 1'b1;
    end else if (rom_ph == 2'd2) begin
      rom_ph <= 2'd0;
      rdy    <= 1'b0;
      inc    <= 1'b0;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        rdy  <= 1'b0;
        inc  <= 1'b0;
      end else begin
        if (cnt != K_ODD) cnt <= nxt;
        rdy <= rdy || (nxt == first_rdy);
        inc <= (nxt == K_INC) || ((nxt > K_INC) && !inc);
      end
    end
  end

  p_dram_start_r2: assert property (@(posedge clk) disable iff (rst)
    idle && req && dram_hit |=> busy && !rdy);

  p_odd_lead_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) && busy && a2q |-> $past(inc));

  p_single_beat_r5: assert property (@(posedge clk) disable iff (rst)
    rdy && busy && !bq |=> !rdy && !busy);

  p_inc_alt_r7: assert property (@(posedge clk) disable iff (rst)
    busy && inc |=> !inc);

  p_rom_ready_r8: assert property (@(posedge clk) disable iff (rst)
    rom_ph == 2'd1 |=> rdy && inc && !busy);

  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    idle && req && addr_hi[1] |=> !busy && !rdy && rom_cs_n);

endmodule

// File: tb/test_ilv_ready_seq.sv
`timescale 1ns/1ps
module test_ilv_ready_seq;
  logic clk = 1'b0, rst = 1'b1, req = 1'b0, burst = 1'b0, addr_b2 = 1'b0;
  logic [1:0] addr_hi = 2'b11;
  logic busy, rdy, inc, rom_cs_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [3:0] v; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  ilv_ready_seq i_ilv_ready_seq (.clk(clk), .rst(rst), .req(req), .burst(burst),
    .addr_hi(addr_hi), .addr_b2(addr_b2), .busy(busy), .rdy(rdy), .inc(inc),
    .rom_cs_n(rom_cs_n));

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {busy,rdy,inc,cs_n} actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(logic b, logic r, logic i, logic c, string tag);
    item_t it;
    it.v = {b, r, i, c};
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, {busy, rdy, inc, rom_cs_n}, it.v);
    end
  end

  // DRAM transfer of n beats; poke issues a stray ROM request in cycle 2 (R10)
  task automatic dram(logic a2, int n, bit poke, string tag);
    int f, last;
    f = a2 ? 4 : 3;
    last = f + n - 1;
    @(negedge clk);
    req = 1'b1; addr_hi = 2'b01; addr_b2 = a2; burst = (n > 1);
    @(posedge clk);
    for (int c = 1; c <= last + 1; c++)
      push(c <= last, c >= f && c <= last, c <= last && c >= 3 && ((c - 3) % 2 == 0), 1'b1, tag);
    for (int c = 1; c <= last + 1; c++) begin
      @(negedge clk);
      req = 1'b0; addr_hi = 2'b11;
      if (poke && c == 2) begin req = 1'b1; addr_hi = 2'b00; end
      burst = (n > 1) && (c < last);
    end
  endtask

  task automatic rom_acc();
    @(negedge clk);
    req = 1'b1; addr_hi = 2'b00; burst = 1'b0;
    @(posedge clk);
    push(1'b0, 1'b0, 1'b1, 1'b0, "R8 rom c1");
    push(1'b0, 1'b1, 1'b1, 1'b0, "R8 rom c2");
    push(1'b0, 1'b0, 1'b0, 1'b1, "R8 rom c3");
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      req = 1'b0; addr_hi = 2'b11;
    end
  endtask

  task automatic unmapped(logic [1:0] a);
    @(negedge clk);
    req = 1'b1; addr_hi = a; burst = 1'b1;
    @(posedge clk);
    for (int c = 1; c <= 3; c++) push(1'b0, 1'b0, 1'b0, 1'b1, "R9 unmapped");
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      req = 1'b0; burst = 1'b0;
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 cs high in reset", {1'b0, 1'b0, 1'b0, rom_cs_n}, 4'b0001);
    repeat (2) @(negedge clk);
    chk("R1 reset state", {busy, rdy, inc, rom_cs_n}, 4'b0001);
    rst = 1'b0;
    dram(1'b0, 1, 1'b0, "R3 R5 even single");
    dram(1'b1, 1, 1'b0, "R4 R5 odd single");
    dram(1'b0, 4, 1'b0, "R6 R7 even burst");
    dram(1'b1, 5, 1'b0, "R4 R6 R7 odd burst");
    dram(1'b0, 2, 1'b1, "R2 R10 busy ignores req");
    rom_acc();
    unmapped(2'b10);
    unmapped(2'b11);
    dram(1'b1, 3, 1'b0, "R2 R6 after rom");
    // R1: reset in the middle of a burst
    @(negedge clk);
    req = 1'b1; addr_hi = 2'b01; addr_b2 = 1'b0; burst = 1'b1;
    repeat (4) @(negedge clk);
    req = 1'b0;
    chk("R1 pre-reset burst active", {busy, rdy, inc, rom_cs_n}, 4'b1101);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-burst reset", {busy, rdy, inc, rom_cs_n}, 4'b0001);
    rst = 1'b0; burst = 1'b0;
    rom_acc();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule